// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire bus target that behaves like a small serial EEPROM of 256 bytes. It samples the bus clock and data lines with the system clock, finds bus start and stop events, and answers only to the fixed 7-bit device address `1010000`. A master writes a word address followed by up to a page of data bytes. The target can also return bytes from a running address pointer, one after another, for as long as the master acknowledges them.

Written bytes are gathered in a 16-byte page buffer. They reach the storage array only after a stop ends the write and a timed programming interval has elapsed. Throughout that interval the target leaves the bus completely alone. The data line is open drain: the block only asserts an output enable that pulls the line low. No back-pressure exists: the target never stretches the clock, so the master alone paces every bit. Both the byte stream into the page buffer and the stream out of the array advance one byte per nine bus clocks.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. Before the first start, bits clocked on the bus get no acknowledge.
- R2: The first byte after a start is sent MSB first. When its upper seven bits equal `1010000`, the target acknowledges by pulling the data line low (`sda_oe`=1) during the ninth clock. Bit 0 selects read (1) or write (0). Any other address gets no acknowledge.
- R3: In a write, the byte after the address is loaded into the address pointer, and every byte of the write is acknowledged.
- R4: A single data byte written at a word address can be read back from that address once the stop and the programming interval have completed.
- R5: A page write keeps the upper four pointer bits fixed and steps the lower four bits with wrap inside the 16-byte page. A 17th or later byte overwrites the earliest buffered location. All buffered bytes are committed together.
- R6: For `PROG_CYCLES` system clocks after a stop that ends a write with data, the target ignores starts and acknowledges no address byte.
- R7: Reads return the byte at the pointer and then increment the pointer. An acknowledge from the master continues the read, and the pointer wraps from 255 to 0.
- R8: After a not-acknowledge from the master, the target stops driving the data line until the next start.
- R9: A repeated start resets address matching, so a write of only a word address followed by a repeated start and a read address performs a random read.
- R10: A read that begins with no preceding word address continues from the current pointer.
- R11: The target asserts the data output enable only while the synchronised clock line is low.
- R12: After reset the output enable is low, the pointer is 0 and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The embedded assertions check on every cycle that the output enable stays low during programming and in the idle state, that it rises only while the clock is low, and that the page buffer is neither loaded nor committed while a programming interval runs. The bench scenarios alone can show the values stored and returned. These include the page wrap and overwrite order, the pointer wrap from 255 to 0, the deferred commit, and the random and current-address reads. They also show that the target stays quiet after a not-acknowledge and before the first start.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_RACK
  } ee_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // data edge while the clock stays high on both samples
  assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_clr,
  input  logic              buf_we,
  input  logic [PAGE_W-1:0] buf_idx,
  input  byte_t             buf_data,
  input  logic              commit,
  input  logic [ADDR_W-PAGE_W-1:0] commit_page,
  input  logic [ADDR_W-1:0] rd_addr,
  output byte_t             rd_data,
  output logic              busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  byte_t mem  [DEPTH];
  byte_t pbuf [PAGE];
  logic [PAGE-1:0]          pmask;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [TW-1:0]            timer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int j = 0; j < PAGE; j++) pbuf[j] <= '0;
      pmask  <= '0;
      page_q <= '0;
      timer  <= '0;
      busy   <= 1'b0;
    end else begin
      if (buf_clr) pmask <= '0;
      if (buf_we) begin
        pbuf[buf_idx]  <= buf_data;
        pmask[buf_idx] <= 1'b1;
      end
      if (commit && !busy) begin
        busy   <= 1'b1;
        timer  <= TW'(PROG_CYCLES - 1);
        page_q <= commit_page;
      end else if (busy) begin
        if (timer == '0) begin
          busy  <= 1'b0;
          pmask <= '0;
          for (int k = 0; k < PAGE; k++)
            if (pmask[k]) mem[{page_q, PAGE_W'(k)}] <= pbuf[k];
        end else begin
          timer <= timer - 1'b1;
        end
      end
    end
  end

  assign rd_data = mem[rd_addr];

  // page buffer must not change during a programming interval
  assert_we_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy);
  // a new commit never arrives while one is running
  assert_commit_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import i2c_ee_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         MEM_BYTES   = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         PROG_CYCLES = 1000000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic busy;
  byte_t rd_data;

  ee_state_e state, ack_next;
  logic [3:0]        cnt;
  byte_t             shreg;
  logic [ADDR_W-1:0] ptr;
  logic              ack_ok;
  logic              have_data;
  logic              buf_we, buf_clr, commit;
  logic [PAGE_W-1:0] buf_idx;
  byte_t             buf_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)) u_array (
    .clk(clk), .rst_n(rst_n), .buf_clr(buf_clr), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_data(buf_data), .commit(commit),
    .commit_page(ptr[ADDR_W-1:PAGE_W]), .rd_addr(ptr), .rd_data(rd_data),
    .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_next  <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      ptr       <= '0;
      ack_ok    <= 1'b0;
      have_data <= 1'b0;
      sda_oe    <= 1'b0;
      buf_we    <= 1'b0;
      buf_clr   <= 1'b0;
      commit    <= 1'b0;
      buf_idx   <= '0;
      buf_data  <= '0;
    end else begin
      buf_we  <= 1'b0;
      buf_clr <= 1'b0;
      commit  <= 1'b0;
      if (stop_p) begin
        sda_oe <= 1'b0;
        state  <= ST_IDLE;
        if (have_data && (state == ST_WDATA ||
                          (state == ST_ACK && ack_next == ST_WDATA)))
          commit <= 1'b1;
        have_data <= 1'b0;
      end else if (start_p && !busy) begin
        // start or repeated start: restart address matching
        sda_oe <= 1'b0;
        cnt    <= '0;
        state  <= ST_DEV;
      end else begin
        unique case (state)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise && cnt != 4'd8) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (state == ST_DEV) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                  ack_next <= shreg[0] ? ST_TX : ST_WADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_WADDR) begin
                ptr       <= shreg[ADDR_W-1:0];
                buf_clr   <= 1'b1;
                have_data <= 1'b0;
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                ack_next  <= ST_WDATA;
              end else begin
                buf_we    <= 1'b1;
                buf_idx   <= ptr[PAGE_W-1:0];
                buf_data  <= shreg;
                ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                have_data <= 1'b1;
                sda_oe    <= 1'b1;
                state     <= ST_ACK;
                ack_next  <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt   <= '0;
              state <= ack_next;
              if (ack_next == ST_TX) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 1'b1;
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              ack_ok <= ~sda_s;
            end else if (scl_fall) begin
              cnt <= '0;
              if (ack_ok) begin
                shreg  <= rd_data;
                sda_oe <= ~rd_data[7];
                ptr    <= ptr + 1'b1;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // silent for the whole programming interval
  assert_quiet_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);
  // drive only begins while the clock is low
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  // idle (after NACK, stop or mismatch) never drives the line
  assert_idle_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
  // bit counter never runs past a full byte
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 4'd8);
endmodule

// File: tb/tb_i2c_eeprom_target.sv
module tb_i2c_eeprom_target;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  int oe_bad = 0;
  logic oe_prev = 1'b0;

  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  i2c_eeprom_target #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R11 monitor: enable must not rise while the bus clock is high
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) oe_bad++;
    oe_prev <= sda_oe;
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(o == e, t, o, e);
      end
    end
  end

  task automatic bus_start();
    wt(3); sda_m = 1'b1; wt(3); scl_m = 1'b1; wt(6);
    sda_m = 1'b0; wt(6); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wt(3); sda_m = 1'b0; wt(3); scl_m = 1'b1; wt(6);
    sda_m = 1'b1; wt(6);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      wt(3); sda_m = b[i]; wt(3); scl_m = 1'b1; wt(8); scl_m = 1'b0;
    end
    wt(3); sda_m = 1'b1; wt(3); scl_m = 1'b1; wt(4);
    ack = sda_line;
    wt(4); scl_m = 1'b0;
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    wt(3); sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(3); scl_m = 1'b1; wt(4); b[i] = sda_line; wt(4); scl_m = 1'b0; wt(3);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    wt(3); scl_m = 1'b1; wt(8); scl_m = 1'b0;
    wt(3); sda_m = 1'b1;
  endtask

  task automatic send(input logic [7:0] b, input bit want_ack, input string tag);
    logic a;
    write_byte(b, a);
    check(a == !want_ack, tag, a, !want_ack);
  endtask

  task automatic rd(input bit give_ack, input logic [7:0] exp, input string tag);
    logic [7:0] b;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    read_byte(give_ack, b);
    obs_q.push_back(b);
  endtask

  task automatic random_read_setup(input logic [7:0] addr);
    bus_start();
    send(8'hA0, 1'b1, "R9 dummy write address ack");
    send(addr, 1'b1, "R3 word address ack");
    bus_start();
    send(8'hA1, 1'b1, "R9 read address ack after repeated start");
  endtask

  function automatic logic [7:0] page_val(input int i);
    if (i == 12) return 8'h20;
    if (i == 13) return 8'h21;
    return 8'h10 + 8'((i - 12) & 15);
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wt(10);
    rst_n = 1'b1;
    wt(5);
    check(sda_oe == 1'b0, "R12 enable low after reset", sda_oe, 0);

    // R1: no start yet, a matching address is not acknowledged
    scl_m = 1'b0;
    send(8'hA0, 1'b0, "R1 no ack before start");

    // R12/R10: current-address read from pointer 0, erased array
    bus_start();
    send(8'hA1, 1'b1, "R2 read address ack");
    rd(1'b0, 8'hFF, "R12 erased byte at pointer 0");
    bus_stop();

    // R2: wrong addresses
    bus_start();
    send(8'hA2, 1'b0, "R2 mismatch low address bits");
    bus_stop();
    bus_start();
    send(8'hB0, 1'b0, "R2 mismatch upper nibble");
    bus_stop();

    // R3/R4/R6: byte write, then probe during programming
    bus_start();
    send(8'hA0, 1'b1, "R2 write address ack");
    send(8'h35, 1'b1, "R3 word address ack");
    send(8'h5A, 1'b1, "R3 data byte ack");
    bus_stop();
    bus_start();
    send(8'hA0, 1'b0, "R6 no ack while programming");
    bus_stop();
    wt(PROG + 100);

    // R4/R9: random read back
    random_read_setup(8'h35);
    rd(1'b0, 8'h5A, "R4 byte write read back");
    bus_stop();

    // R10: current address continues at 0x36
    bus_start();
    send(8'hA1, 1'b1, "R10 read address ack");
    rd(1'b0, 8'hFF, "R10 current address read at 0x36");
    bus_stop();

    // R5: 18-byte page write starting mid page at 0x4C
    bus_start();
    send(8'hA0, 1'b1, "R5 address ack");
    send(8'h4C, 1'b1, "R5 word address ack");
    for (int k = 0; k < 18; k++) send(8'h10 + 8'(k), 1'b1, "R5 page data ack");
    bus_stop();
    wt(PROG + 100);

    // R5/R7: read the page sequentially
    random_read_setup(8'h40);
    for (int i = 0; i < 16; i++)
      rd(i != 15, page_val(i), "R5 page content after wrap and overwrite");
    bus_stop();

    // R7: pointer wrap 255 -> 0
    bus_start();
    send(8'hA0, 1'b1, "R3 address ack");
    send(8'hFF, 1'b1, "R3 word address ack");
    send(8'h77, 1'b1, "R3 data ack");
    bus_stop();
    wt(PROG + 100);
    bus_start();
    send(8'hA0, 1'b1, "R3 address ack");
    send(8'h00, 1'b1, "R3 word address ack");
    send(8'h66, 1'b1, "R3 data ack");
    bus_stop();
    wt(PROG + 100);
    random_read_setup(8'hFE);
    rd(1'b1, 8'hFF, "R7 byte at 0xFE");
    rd(1'b1, 8'h77, "R7 byte at 0xFF");
    rd(1'b0, 8'h66, "R7 wrap to 0x00");
    bus_stop();

    // R8: after NACK the line stays released
    random_read_setup(8'h4E);
    rd(1'b0, 8'h12, "R8 byte before NACK");
    rd(1'b0, 8'hFF, "R8 released after NACK");
    bus_stop();

    wt(20);
    check(oe_bad == 0, "R11 enable rises only while clock low", oe_bad, 0);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule